// File: doc/BRIEF.md
# Palette RAM Sequenced Write Port

This block is a 256-entry color lookup table whose host side is a byte-wide, register-mapped write port. The host loads an entry index into an index register and then writes three color bytes, red first, then green, then blue, to a color data register. The three bytes are gathered into one 24-bit entry. The entry is written into the table only when the blue byte arrives. The index then steps forward by one, so a run of entries can be loaded without reloading the index.

A second data register uses the same index register to reach a small bank of indirect DAC control registers. These are a pixel-depth control byte, a memory-bank select and two auxiliary bytes. Their values are driven out as ports. On the pixel side, an 8-bit index returns its 24-bit color one clock later.

Top module: `palette_ram_port`

## Requirements
- R1: The table holds 256 entries of 24 bits. `pix_rgb_o` carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R2: A host write is qualified by `host_we_i`. `host_sel_i` selects the target: 0 loads the index register, 1 writes the color data register, 2 writes the indirect control data register, and 3 has no effect on any state.
- R3: Color bytes are taken in the fixed order red, green, blue. A write to the index register returns the sequence to red.
- R4: An entry is written only on the blue byte. After a red byte alone, or red and green, the table entry keeps its old value.
- R5: After each blue byte the index register increments by one and wraps from 255 to 0.
- R6: A pixel read returns the entry addressed by `pix_idx_i` one clock after the index is presented. If an entry is written and read in the same cycle, the read returns the old value.
- R7: A control data write updates the indirect register selected by the index register. Index 0x20 drives `depth_ctrl_o` (for example 0x10, 0x14 or 0x18 for 8, 16 or 32 bpp with one bank, and 0x20, 0x24 or 0x28 with two banks). Index 0x21 drives `bank_sel_o`, 0x10 drives `aux_lo_o` and 0x11 drives `aux_hi_o`. A control write changes neither the index nor the color sequence.
- R8: A control data write while the index register holds any other value changes no control output.
- R9: After reset all four control outputs are zero, the index register is 0 and the color sequence expects red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Host register select |
| host_wdata_i | input | 8 | Host write byte |
| pix_idx_i | input | 8 | Pixel-side table index |
| pix_rgb_o | output | 24 | Color for the previous cycle's index |
| depth_ctrl_o | output | 8 | Indirect register 0x20 |
| bank_sel_o | output | 8 | Indirect register 0x21 |
| aux_lo_o | output | 8 | Indirect register 0x10 |
| aux_hi_o | output | 8 | Indirect register 0x11 |

## Verification
The hardest state to reach from the ports is the middle of a triplet when something other than a color byte arrives. The stimulus creates this by placing an index reload, a no-op select or a control write between the red and blue bytes, and then reading the entry back. The other awkward case is a pixel read of the very entry that is being committed on the same edge. The driver produces it by presenting the blue byte and the matching pixel index at the same falling edge. The wrap of the index from 255 to 0 is reached by streaming two triplets after loading index 255.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 8;
  localparam int RGB_W  = 3 * COMP_W;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_COLOR = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int CW = COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [IW-1:0]     idx_o,
  output logic              commit_o,
  output logic [3*CW-1:0]   commit_data_o,
  output logic              ctrl_we_o
);
  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] red_q, grn_q;
  logic          idx_wr, col_wr;

  assign idx_wr    = we_i && (sel_i == SEL_INDEX);
  assign col_wr    = we_i && (sel_i == SEL_COLOR);
  assign ctrl_we_o = we_i && (sel_i == SEL_CTRL);
  assign commit_o  = col_wr && (phase_q == PH_BLU);
  assign commit_data_o = {red_q, grn_q, wdata_i};
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (idx_wr) begin
      idx_q   <= wdata_i[IW-1:0];
      phase_q <= PH_RED;
    end else if (col_wr) begin
      unique case (phase_q)
        PH_RED:  begin red_q <= wdata_i; phase_q <= PH_GRN; end
        PH_GRN:  begin grn_q <= wdata_i; phase_q <= PH_BLU; end
        default: begin idx_q <= idx_q + 1'b1; phase_q <= PH_RED; end
      endcase
    end
  end

  p_phase_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);
  p_phase_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> phase_q == PH_RED);
  p_autoinc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> idx_q == IW'($past(idx_q) + 1'b1));
  p_ctrl_keeps_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> $stable(phase_q) && $stable(idx_q));
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << IW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i]; // read-before-write on collision
  end
endmodule

// File: rtl/pal_ctrl_regs.sv
module pal_ctrl_regs #(
  parameter int IW = 8,
  parameter int CW = 8,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][IW-1:0] REG_ADDR = {8'h21, 8'h20, 8'h11, 8'h10}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IW-1:0]            addr_i,
  input  logic [CW-1:0]            wdata_i,
  output logic [NREG-1:0][CW-1:0]  regs_o
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = (addr_i == REG_ADDR[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              regs_o[g] <= '0;
      else if (we_i && hit[g])  regs_o[g] <= wdata_i;
    end
  end

  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit == '0) |=> $stable(regs_o));
  p_single_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/palette_ram_port.sv
module palette_ram_port
  import pal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [1:0]        host_sel_i,
  input  logic [COMP_W-1:0] host_wdata_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [RGB_W-1:0]  pix_rgb_o,
  output logic [COMP_W-1:0] depth_ctrl_o,
  output logic [COMP_W-1:0] bank_sel_o,
  output logic [COMP_W-1:0] aux_lo_o,
  output logic [COMP_W-1:0] aux_hi_o
);
  localparam int NREG = 4;

  logic [IDX_W-1:0]             idx;
  logic                         commit, ctrl_we;
  logic [RGB_W-1:0]             commit_data;
  logic [NREG-1:0][COMP_W-1:0]  ctrl_regs;

  pal_seq #(.IW(IDX_W), .CW(COMP_W)) u_seq (
    .clk_i, .rst_ni,
    .we_i(host_we_i), .sel_i(host_sel_i), .wdata_i(host_wdata_i),
    .idx_o(idx), .commit_o(commit), .commit_data_o(commit_data),
    .ctrl_we_o(ctrl_we)
  );

  pal_ram #(.IW(IDX_W), .DW(RGB_W)) u_ram (
    .clk_i, .we_i(commit), .waddr_i(idx), .wdata_i(commit_data),
    .raddr_i(pix_idx_i), .rdata_o(pix_rgb_o)
  );

  pal_ctrl_regs #(.IW(IDX_W), .CW(COMP_W), .NREG(NREG),
                  .REG_ADDR({8'h21, 8'h20, 8'h11, 8'h10})) u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we), .addr_i(idx),
    .wdata_i(host_wdata_i), .regs_o(ctrl_regs)
  );

  assign aux_lo_o     = ctrl_regs[0];
  assign aux_hi_o     = ctrl_regs[1];
  assign depth_ctrl_o = ctrl_regs[2];
  assign bank_sel_o   = ctrl_regs[3];
endmodule

// File: tb/sim_palette_ram_port.sv
module sim_palette_ram_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic [7:0]  depth_ctrl, bank_sel, aux_lo, aux_hi;

  int n_tests = 0, n_fail = 0;
  logic        rd_issue = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  palette_ram_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .host_we_i(host_we), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .pix_idx_i(pix_idx), .pix_rgb_o(pix_rgb),
    .depth_ctrl_o(depth_ctrl), .bank_sel_o(bank_sel),
    .aux_lo_o(aux_lo), .aux_hi_o(aux_hi)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: output registered at the edge where rd_issue was seen
  always begin
    logic took;
    @(posedge clk);
    took = rd_issue;
    #1;
    if (took) begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (pix_rgb !== e) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", t, pix_rgb, e);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    host_we = 1'b0; rd_issue = 1'b0;
  endtask

  task automatic hw(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d; rd_issue = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, logic [23:0] e, string tag);
    @(negedge clk);
    host_we = 1'b0; pix_idx = idx; rd_issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic triplet(logic [23:0] c);
    hw(2'd1, c[23:16]); hw(2'd1, c[15:8]); hw(2'd1, c[7:0]);
  endtask

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9 reset values
    @(negedge clk);
    check8("R9 depth", depth_ctrl, 8'h00);
    check8("R9 bank", bank_sel, 8'h00);
    check8("R9 aux_lo", aux_lo, 8'h00);
    check8("R9 aux_hi", aux_hi, 8'h00);
    // R9: index 0, phase red without index write
    triplet(24'hA1B2C3);
    rd(8'h00, 24'hA1B2C3, "R9 R1 entry0");
    // R5: auto-increment to 1
    triplet(24'h112233);
    rd(8'h01, 24'h112233, "R5 autoinc");
    // R2: explicit index load, R1 component order
    hw(2'd0, 8'h40);
    triplet(24'hFF0080);
    rd(8'h40, 24'hFF0080, "R2 R1 index load");
    // R4: partial triplet leaves entry
    hw(2'd0, 8'h40);
    hw(2'd1, 8'h01); hw(2'd1, 8'h02);
    rd(8'h40, 24'hFF0080, "R4 partial");
    // R3: index reload restarts at red
    hw(2'd0, 8'h40);
    triplet(24'h0A0B0C);
    rd(8'h40, 24'h0A0B0C, "R3 restart");
    // R2: select 3 mid-triplet does nothing
    hw(2'd0, 8'h41);
    hw(2'd1, 8'h55); hw(2'd3, 8'h99); hw(2'd1, 8'h66); hw(2'd1, 8'h77);
    rd(8'h41, 24'h556677, "R2 sel3 noop");
    // R6: same-cycle commit and read returns old, next returns new
    hw(2'd0, 8'h41);
    hw(2'd1, 8'h12); hw(2'd1, 8'h34);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'd1; host_wdata = 8'h56;
    pix_idx = 8'h41; rd_issue = 1'b1;
    exp_q.push_back(24'h556677); tag_q.push_back("R6 collision old");
    rd(8'h41, 24'h123456, "R6 after write");
    // R5: wrap 255 -> 0
    hw(2'd0, 8'hFF);
    triplet(24'hDEAD01);
    triplet(24'hBEEF02);
    rd(8'hFF, 24'hDEAD01, "R5 entry255");
    rd(8'h00, 24'hBEEF02, "R5 wrap");
    // R7: control writes
    hw(2'd0, 8'h20); hw(2'd2, 8'h14);
    hw(2'd0, 8'h21); hw(2'd2, 8'h01);
    hw(2'd0, 8'h10); hw(2'd2, 8'hAA);
    hw(2'd0, 8'h11); hw(2'd2, 8'h5B);
    idle();
    check8("R7 depth", depth_ctrl, 8'h14);
    check8("R7 bank", bank_sel, 8'h01);
    check8("R7 aux_lo", aux_lo, 8'hAA);
    check8("R7 aux_hi", aux_hi, 8'h5B);
    // R7: control write mid-triplet keeps index and phase
    hw(2'd0, 8'h20);
    hw(2'd1, 8'hC1); hw(2'd2, 8'h28); hw(2'd1, 8'hC2); hw(2'd1, 8'hC3);
    rd(8'h20, 24'hC1C2C3, "R7 ctrl keeps seq");
    idle();
    check8("R7 depth 2bank", depth_ctrl, 8'h28);
    // R8: unlisted index ignored
    hw(2'd0, 8'h22); hw(2'd2, 8'hEE);
    hw(2'd0, 8'h00); hw(2'd2, 8'hEE);
    idle();
    check8("R8 depth", depth_ctrl, 8'h28);
    check8("R8 bank", bank_sel, 8'h01);
    check8("R8 aux_lo", aux_lo, 8'hAA);
    check8("R8 aux_hi", aux_hi, 8'h5B);
    // R1: earlier entries intact
    rd(8'h01, 24'h112233, "R1 retain");
    idle(); idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule